// File: doc/BRIEF.md
# Per-Channel Interrupt Status and Clear Unit

This block keeps one pending-event flag for each of four conversion channels. A one-cycle completion pulse from a channel sets its flag, and the flag stays set until software clears it. Software programs an enable mask. It can read the unmasked flags, the mask and the masked status at three separate word addresses. For each channel the block drives a level interrupt that is the flag gated by the mask.

Clearing is write-one-to-clear on the masked status address. A 1 in a channel's bit position clears that channel's pending flag. This works whether or not the mask enables the channel, so a driver that polls the unmasked flags with interrupts disabled still clears them through the same address.

The register port is a flat single-cycle bus. Writes are captured on the rising clock edge. Read data is a combinational function of the address.

Top module: `irq_status_unit`

## Requirements
- R1: After synchronous active-high reset, the pending flags, the mask and all four interrupt outputs are 0.
- R2: A 1 on `set_pulse[i]` at a clock edge sets pending flag i. The flag reads as 1 in bit i at address 0x0 from the next cycle on.
- R3: Address 0x8 reads, in bits 3:0, the bitwise AND of the pending flags and the mask.
- R4: A write to address 0x4 loads bits 3:0 of the write data into the mask. Reading 0x4 returns the mask in bits 3:0.
- R5: A write to 0x8 clears pending flag i from the next cycle for every data bit i that is 1. A 0 in a data bit leaves that flag unchanged, and no flag changes without a set pulse or such a clear.
- R6: The clear of R5 also works on a channel whose mask bit is 0.
- R7: `irq_out[i]` is 1 exactly while pending flag i and mask bit i are both 1. It holds for as long as both stay set, and it equals bits 3:0 read at address 0x8.
- R8: When a set pulse and a clearing write hit the same channel in the same cycle, the flag ends up set.
- R9: Read bits 31:4 are always 0, and reads of any address other than 0x0, 0x4 or 0x8 return 0. Writes to 0x0 and to unmapped addresses change no state, and write-data bits 31:4 are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_pulse | input | 4 | Per-channel completion pulses that set the pending flags |
| bus_addr | input | 4 | Register byte address |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_out | output | 4 | Per-channel level interrupts |

## Verification
A stuck or wrongly cleared pending flag shows up on `irq_out` and in the address 0x0 read one cycle after the edge that should have changed it. The bench compares both against a behavioural model on every cycle, so such a fault is caught within a single clock. A mask-gating fault shows up only once the mask is nonzero. A clear that wrongly depends on the mask shows up only when a masked-off channel is cleared. The stimulus therefore covers both mask states, simultaneous set and clear, and the writes that must be ignored.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;

    localparam int NUM_CH_DEF = 4;
    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 4;

    typedef enum logic [ADDR_W-1:0] {
        REG_PENDING = 4'h0,
        REG_ENABLE  = 4'h4,
        REG_MSTATUS = 4'h8
    } reg_addr_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              we;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    function automatic logic hits(input bus_req_t req, input reg_addr_e target);
        return req.we && (req.addr == target);
    endfunction

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import irq_status_pkg::*;
#(
    parameter int NUM_CH = NUM_CH_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] set_vec,
    input  logic [NUM_CH-1:0] clr_vec,
    output logic [NUM_CH-1:0] flags
);

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                flags[ch] <= 1'b0;
            else if (set_vec[ch])
                flags[ch] <= 1'b1;   // set has priority: no event is lost
            else if (clr_vec[ch])
                flags[ch] <= 1'b0;
        end
    end

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
    import irq_status_pkg::*;
#(
    parameter int NUM_CH = NUM_CH_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [NUM_CH-1:0] din,
    output logic [NUM_CH-1:0] mask
);

    always_ff @(posedge clk) begin
        if (rst)
            mask <= '0;
        else if (load)
            mask <= din;
    end

endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
    import irq_status_pkg::*;
#(
    parameter int NUM_CH = NUM_CH_DEF
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [NUM_CH-1:0] pending,
    input  logic [NUM_CH-1:0] mask,
    input  logic [NUM_CH-1:0] mstatus,
    output logic [DATA_W-1:0] rdata
);

    always_comb begin
        rdata = '0;
        if (addr == REG_PENDING)
            rdata[NUM_CH-1:0] = pending;
        else if (addr == REG_ENABLE)
            rdata[NUM_CH-1:0] = mask;
        else if (addr == REG_MSTATUS)
            rdata[NUM_CH-1:0] = mstatus;
    end

endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
    import irq_status_pkg::*;
#(
    parameter int NUM_CH = NUM_CH_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] set_pulse,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] irq_out
);

    localparam int CH_W = NUM_CH;

    bus_req_t          req;
    logic [CH_W-1:0]   clr_vec;
    logic              mask_load;
    logic [CH_W-1:0]   raw_q;
    logic [CH_W-1:0]   mask_q;
    logic [CH_W-1:0]   mstatus;

    assign req       = '{addr: bus_addr, we: bus_we, wdata: bus_wdata};
    assign clr_vec   = hits(req, REG_MSTATUS) ? req.wdata[CH_W-1:0] : '0;
    assign mask_load = hits(req, REG_ENABLE);
    assign mstatus   = raw_q & mask_q;
    assign irq_out   = mstatus;

    irq_flag_bank #(.NUM_CH(CH_W)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_pulse),
        .clr_vec (clr_vec),
        .flags   (raw_q)
    );

    irq_mask_reg #(.NUM_CH(CH_W)) u_mask (
        .clk  (clk),
        .rst  (rst),
        .load (mask_load),
        .din  (req.wdata[CH_W-1:0]),
        .mask (mask_q)
    );

    irq_read_mux #(.NUM_CH(CH_W)) u_rmux (
        .addr    (bus_addr),
        .pending (raw_q),
        .mask    (mask_q),
        .mstatus (mstatus),
        .rdata   (bus_rdata)
    );

endmodule

// File: rtl/irq_status_checker.sv
module irq_status_checker
    import irq_status_pkg::*;
#(
    parameter int NUM_CH = NUM_CH_DEF
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_CH-1:0] set_pulse,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [NUM_CH-1:0] irq_out,
    input logic [NUM_CH-1:0] raw_q,
    input logic [NUM_CH-1:0] mask_q
);

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (raw_q == '0 && mask_q == '0 && irq_out == '0));

    assert_set_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(set_pulse) != '0)
            |-> ((raw_q & $past(set_pulse)) == $past(set_pulse)));

    assert_mask_load_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(bus_we) && $past(bus_addr) == REG_ENABLE)
            |-> (mask_q == $past(bus_wdata[NUM_CH-1:0])));

    assert_w1c_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(bus_we) && $past(bus_addr) == REG_MSTATUS)
            |-> ((raw_q & $past(bus_wdata[NUM_CH-1:0]) & ~$past(set_pulse)) == '0));

    assert_no_stray_change_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(set_pulse) == '0
            && !($past(bus_we) && $past(bus_addr) == REG_MSTATUS))
            |-> (raw_q == $past(raw_q)));

    assert_irq_matches_status_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == REG_MSTATUS) |-> (bus_rdata[NUM_CH-1:0] == irq_out));

    assert_upper_zero_R9: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[DATA_W-1:NUM_CH] == '0);

endmodule

bind irq_status_unit irq_status_checker #(.NUM_CH(NUM_CH)) u_checker (
    .clk       (clk),
    .rst       (rst),
    .set_pulse (set_pulse),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out),
    .raw_q     (raw_q),
    .mask_q    (mask_q)
);

// File: tb/test_irq_status_unit.sv
`timescale 1ns/1ps
module test_irq_status_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  set_pulse = '0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    bit [3:0] m_raw = 0;
    bit [3:0] m_mask = 0;

    always #5 clk = ~clk;

    irq_status_unit i_irq_status_unit (
        .clk(clk), .rst(rst), .set_pulse(set_pulse), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    // behavioural reference model
    always @(posedge clk) begin
        if (rst) begin
            m_raw  = 0;
            m_mask = 0;
        end else begin
            bit [3:0] clr;
            clr = (bus_we && bus_addr == 4'h8) ? bus_wdata[3:0] : 4'h0;
            m_raw = set_pulse | (m_raw & ~clr);
            if (bus_we && bus_addr == 4'h4) m_mask = bus_wdata[3:0];
        end
    end

    function automatic logic [31:0] model_read(input logic [3:0] a);
        case (a)
            4'h0:    return {28'h0, m_raw};
            4'h4:    return {28'h0, m_mask};
            4'h8:    return {28'h0, m_raw & m_mask};
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #2;
        if (!rst && !done) begin
            check("R7 irq_out per cycle", {28'h0, irq_out}, {28'h0, m_raw & m_mask});
            check("R9 rdata per cycle", bus_rdata, model_read(bus_addr));
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] pulse);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1; set_pulse = pulse;
        @(negedge clk);
        bus_we = 1'b0; set_pulse = '0; bus_wdata = '0;
    endtask

    task automatic pulse(input logic [3:0] p);
        @(negedge clk);
        set_pulse = p;
        @(negedge clk);
        set_pulse = '0;
    endtask

    task automatic rd(input string req, input logic [3:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        rd("R1 pending after reset", 4'h0, 32'h0);
        rd("R1 mask after reset", 4'h4, 32'h0);
        check("R1 irq after reset", {28'h0, irq_out}, 32'h0);

        pulse(4'b0101);
        rd("R2 pending set", 4'h0, 32'h5);
        rd("R3 status with mask zero", 4'h8, 32'h0);

        wr(4'h4, 32'h0000_000F, 4'h0);
        rd("R4 mask readback", 4'h4, 32'hF);
        rd("R3 status masked", 4'h8, 32'h5);
        check("R7 irq level", {28'h0, irq_out}, 32'h5);
        repeat (4) @(negedge clk);
        check("R7 irq held", {28'h0, irq_out}, 32'h5);

        wr(4'h8, 32'h0, 4'h0);
        rd("R5 zero write no effect", 4'h0, 32'h5);
        wr(4'h8, 32'h1, 4'h0);
        rd("R5 w1c clears pending", 4'h0, 32'h4);
        check("R5 irq after clear", {28'h0, irq_out}, 32'h4);

        wr(4'h4, 32'h0, 4'h0);
        pulse(4'b0010);
        rd("R6 pending before masked clear", 4'h0, 32'h6);
        wr(4'h8, 32'h2, 4'h0);
        rd("R6 masked-off clear", 4'h0, 32'h4);

        wr(4'h8, 32'h4, 4'b0100);
        rd("R8 set wins over clear", 4'h0, 32'h4);

        wr(4'h4, 32'hFFFF_FFF0, 4'h0);
        rd("R9 upper mask bits dropped", 4'h4, 32'h0);
        wr(4'h0, 32'hFFFF_FFFF, 4'h0);
        rd("R9 pending read-only", 4'h0, 32'h4);
        wr(4'hC, 32'hFFFF_FFFF, 4'h0);
        rd("R9 unmapped read zero", 4'hC, 32'h0);
        rd("R9 unmapped write ignored", 4'h0, 32'h4);
        wr(4'h4, 32'hFFFF_FFFF, 4'h0);
        rd("R9 mask only low bits", 4'h4, 32'hF);
        rd("R3 status final", 4'h8, 32'h4);

        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule